// File: doc/BRIEF.md
# Transmit Clock Watchdog and Line-Driver Tri-State Control

This block runs on a free-running master clock and supervises the transmit clock that feeds the line driver. The transmit clock arrives as a raw level. It passes through a synchroniser into the master-clock domain, and a change of its level counts as activity. If the synchronised level holds still, whether high or low, for more than a fixed number of master-clock cycles, the block reports the transmit clock as missing. When the clock changes level again, the report clears.

A new missing condition sets a sticky interrupt flag, provided the interrupt is not masked. Software clears the flag with a one-cycle write-one-to-clear pulse.

The block also merges several conditions into one registered tri-state enable for the line driver:
- a tri-state pin;
- a tri-state control bit;
- a lost master clock;
- a powered-down transmit path;
- the missing transmit clock.

A missing transmit clock does not force the driver off in two cases: remote loopback, and transmission of an internal pattern timed by the master clock. The driver is tri-stated out of reset.

Top module: `txclk_guard`

## Requirements
- R1: During and right after reset, `drv_hiz` = 1, `tclk_missing` = 1 and `tclk_irq` = 0.
- R2: A level change on `tclk_in` clears `tclk_missing` on the third rising master-clock edge after the change: two synchroniser stages, then one register. The same event restarts the stuck-level count.
- R3: If `tclk_in` holds a constant level, `tclk_missing` rises on the 74th rising edge after its last change, that is, after 71 stable cycles in the synchronised domain. This holds for a stuck-low and a stuck-high level alike. The flag stays at 1 while the level stays stuck.
- R4: When `tclk_missing` goes from 0 to 1 and `irq_mask` was 0 in the cycle before, `tclk_irq` rises on that same edge.
- R5: `tclk_irq` stays at 1 until `irq_clr` is 1 at a rising edge, which clears it on that edge. A restarted transmit clock does not clear it.
- R6: `tclk_irq` never rises except together with a 0-to-1 change of `tclk_missing`. A transition that occurs while `irq_mask` = 1 leaves `tclk_irq` at 0.
- R7: Each of `tz_pin`, `tz_bit`, `mclk_lost` and `tx_pdn` at 1 drives `drv_hiz` to 1 one edge later. `drv_hiz` returns to 0 one edge after all of them and the missing term are inactive.
- R8: With `tclk_missing` = 1, `drv_hiz` is 1 one edge later unless `rloop_mode` or `int_pat_mode` is 1. In either of those modes, the missing clock alone leaves `drv_hiz` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Free-running master clock |
| rst | input | 1 | Asynchronous reset, active high |
| tclk_in | input | 1 | Raw transmit clock level |
| tz_pin | input | 1 | Tri-state request from the pin |
| tz_bit | input | 1 | Tri-state request from the control bit |
| mclk_lost | input | 1 | Master clock reported lost |
| tx_pdn | input | 1 | Transmit path powered down |
| rloop_mode | input | 1 | Remote loopback mode active |
| int_pat_mode | input | 1 | Internal pattern sent on the master clock |
| irq_mask | input | 1 | Masks setting of the missing-clock interrupt |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt |
| tclk_missing | output | 1 | Transmit clock missing status |
| tclk_irq | output | 1 | Sticky missing-clock interrupt |
| drv_hiz | output | 1 | Line-driver high-impedance enable |

## Verification
Faults in the stuck-level counter show up at the ports as a wrong timeout. A wrong limit or a missed restart moves the rise of `tclk_missing` away from its exact edge, so the bench pins that edge down to within one cycle, for both stuck levels. A fault in the synchroniser or the edge detector shows up as a clearing latency other than three edges. A fault in the interrupt or tri-state logic shows up one edge after its cause: `tclk_irq` leaking past the mask, losing its stickiness or ignoring the clear pulse, or `drv_hiz` ignoring a cause or an exemption mode.

// File: rtl/txg_pkg.sv
package txg_pkg;

    // Registered outputs of the interrupt and tri-state stage.
    typedef struct packed {
        logic irq;
        logic hiz;
    } ctrl_state_t;

    // Reset value: driver tri-stated, no interrupt pending.
    localparam ctrl_state_t CTRL_RESET = '{irq: 1'b0, hiz: 1'b1};

endpackage

// File: rtl/txg_edge_sync.sv
module txg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_seen
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
        logic          prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[LAST-1:0], async_in};
        st_d.prev  = st_q.chain[LAST];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Activity: the synchronised level differs from the level one cycle earlier.
    assign edge_seen = st_q.chain[LAST] ^ st_q.prev;

endmodule

// File: rtl/txg_stuck_timer.sv
module txg_stuck_timer #(
    parameter int LIMIT = 70
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic missing,
    output logic missing_rise
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          miss;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_seen) begin
            st_d.cnt  = '0;
            st_d.miss = 1'b0;
        end else begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.miss = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.miss <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign missing      = st_q.miss;
    assign missing_rise = st_d.miss & ~st_q.miss;

endmodule

// File: rtl/txg_drv_ctrl.sv
module txg_drv_ctrl
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic missing,
    input  logic missing_rise,
    input  logic tz_pin,
    input  logic tz_bit,
    input  logic mclk_lost,
    input  logic tx_pdn,
    input  logic rloop_mode,
    input  logic int_pat_mode,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic irq,
    output logic hiz
);
    ctrl_state_t st_d, st_q;
    logic        force_off;
    logic        miss_off;

    always_comb begin
        force_off = tz_pin | tz_bit | mclk_lost | tx_pdn;
        miss_off  = missing & ~rloop_mode & ~int_pat_mode;
        st_d      = st_q;
        st_d.hiz  = force_off | miss_off;
        // A new missing event takes priority over a simultaneous clear.
        st_d.irq  = (st_q.irq & ~irq_clr) | (missing_rise & ~irq_mask);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
    assign hiz = st_q.hiz;

endmodule

// File: rtl/txclk_guard.sv
module txclk_guard #(
    parameter int SYNC_STAGES = 2,
    parameter int STUCK_LIMIT = 70
) (
    input  logic mclk,
    input  logic rst,
    input  logic tclk_in,
    input  logic tz_pin,
    input  logic tz_bit,
    input  logic mclk_lost,
    input  logic tx_pdn,
    input  logic rloop_mode,
    input  logic int_pat_mode,
    input  logic irq_mask,
    input  logic irq_clr,
    output logic tclk_missing,
    output logic tclk_irq,
    output logic drv_hiz
);
    logic edge_seen;
    logic miss;
    logic miss_rise;

    txg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (mclk),
        .rst       (rst),
        .async_in  (tclk_in),
        .edge_seen (edge_seen)
    );

    txg_stuck_timer #(.LIMIT(STUCK_LIMIT)) u_timer (
        .clk          (mclk),
        .rst          (rst),
        .edge_seen    (edge_seen),
        .missing      (miss),
        .missing_rise (miss_rise)
    );

    txg_drv_ctrl u_ctrl (
        .clk          (mclk),
        .rst          (rst),
        .missing      (miss),
        .missing_rise (miss_rise),
        .tz_pin       (tz_pin),
        .tz_bit       (tz_bit),
        .mclk_lost    (mclk_lost),
        .tx_pdn       (tx_pdn),
        .rloop_mode   (rloop_mode),
        .int_pat_mode (int_pat_mode),
        .irq_mask     (irq_mask),
        .irq_clr      (irq_clr),
        .irq          (tclk_irq),
        .hiz          (drv_hiz)
    );

    assign tclk_missing = miss;

endmodule

// File: rtl/txclk_guard_chk.sv
module txclk_guard_chk (
    input logic mclk,
    input logic rst,
    input logic tz_pin,
    input logic tz_bit,
    input logic mclk_lost,
    input logic tx_pdn,
    input logic rloop_mode,
    input logic int_pat_mode,
    input logic irq_mask,
    input logic irq_clr,
    input logic tclk_missing,
    input logic tclk_irq,
    input logic drv_hiz
);
    // R4
    irq_on_new_miss_chk: assert property (@(posedge mclk) disable iff (rst)
        ($rose(tclk_missing) && !$past(irq_mask)) |-> tclk_irq);

    // R6
    irq_only_on_rise_chk: assert property (@(posedge mclk) disable iff (rst)
        $rose(tclk_irq) |-> $rose(tclk_missing));

    // R5
    irq_sticky_chk: assert property (@(posedge mclk) disable iff (rst)
        (tclk_irq && !irq_clr) |=> tclk_irq);

    // R7
    forced_hiz_chk: assert property (@(posedge mclk) disable iff (rst)
        (tz_pin || tz_bit || mclk_lost || tx_pdn) |=> drv_hiz);

    // R8
    miss_hiz_chk: assert property (@(posedge mclk) disable iff (rst)
        (tclk_missing && !rloop_mode && !int_pat_mode) |=> drv_hiz);

    // R8
    exempt_release_chk: assert property (@(posedge mclk) disable iff (rst)
        (!tz_pin && !tz_bit && !mclk_lost && !tx_pdn && (rloop_mode || int_pat_mode)) |=> !drv_hiz);

endmodule

bind txclk_guard txclk_guard_chk u_chk (.*);

// File: tb/sim_txclk_guard.sv
module sim_txclk_guard;
    logic mclk = 1'b0;
    logic rst  = 1'b1;
    logic tclk_in = 1'b0, tz_pin = 1'b0, tz_bit = 1'b0, mclk_lost = 1'b0, tx_pdn = 1'b0;
    logic rloop_mode = 1'b0, int_pat_mode = 1'b0, irq_mask = 1'b0, irq_clr = 1'b0;
    logic tclk_missing, tclk_irq, drv_hiz;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    bit   run   = 0;
    int   ph    = 0;

    typedef struct {
        string req;
        int    sel;
        logic  exp;
    } item_t;
    item_t sb[$];

    always #2 mclk = ~mclk;

    txclk_guard u0 (.*);

    // Free-running transmit clock source, toggles every three master cycles.
    always @(negedge mclk) begin
        if (run) begin
            ph = ph + 1;
            if (ph >= 3) begin
                tclk_in = ~tclk_in;
                ph = 0;
            end
        end
    end

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            wait (sb.size() > 0);
            begin
                item_t it;
                logic  act;
                it  = sb.pop_front();
                act = (it.sel == 0) ? tclk_missing : (it.sel == 1) ? tclk_irq : drv_hiz;
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b t=%0t", it.req, it.sel, act, it.exp, $time);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic exp);
        sb.push_back('{req: req, sel: sel, exp: exp});
        wait (sb.size() == 0);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge mclk);
        #1;
    endtask

    // Stop the source and make one final change to the given level.
    task automatic stop_at(input logic lvl);
        run = 0;
        cyc(1);
        if (tclk_in == lvl) begin
            tclk_in = ~lvl;
            cyc(5);
        end
        tclk_in = lvl;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        cyc(3);
        // R1: reset state
        expect_val("R1", 2, 1'b1);
        expect_val("R1", 0, 1'b1);
        expect_val("R1", 1, 1'b0);
        rst = 1'b0;
        cyc(1);
        expect_val("R1", 2, 1'b1);

        // R2: running clock clears missing, no interrupt from reset state
        run = 1;
        cyc(20);
        expect_val("R2", 0, 1'b0);
        expect_val("R4", 1, 1'b0);
        expect_val("R7", 2, 1'b0);

        // R3: stuck low, exact timeout edge
        stop_at(1'b0);
        cyc(73);
        expect_val("R3", 0, 1'b0);
        expect_val("R4", 1, 1'b0);
        cyc(1);
        expect_val("R3", 0, 1'b1);
        expect_val("R4", 1, 1'b1);
        cyc(1);
        expect_val("R8", 2, 1'b1);
        cyc(30);
        expect_val("R3", 0, 1'b1);

        // R8: exemption modes
        rloop_mode = 1;
        cyc(1);
        expect_val("R8", 2, 1'b0);
        rloop_mode = 0;
        int_pat_mode = 1;
        cyc(1);
        expect_val("R8", 2, 1'b0);
        int_pat_mode = 0;
        cyc(1);
        expect_val("R8", 2, 1'b1);

        // R2: edge clears missing on the third edge
        tclk_in = ~tclk_in;
        cyc(2);
        expect_val("R2", 0, 1'b1);
        cyc(1);
        expect_val("R2", 0, 1'b0);

        // R5: interrupt sticky over a restarted clock, cleared by pulse
        run = 1;
        cyc(10);
        expect_val("R5", 1, 1'b1);
        irq_clr = 1;
        cyc(1);
        irq_clr = 0;
        expect_val("R5", 1, 1'b0);
        cyc(5);
        expect_val("R5", 1, 1'b0);

        // R7: each forcing cause, with the clock present
        expect_val("R7", 2, 1'b0);
        tz_pin = 1; cyc(1); expect_val("R7", 2, 1'b1); tz_pin = 0; cyc(1); expect_val("R7", 2, 1'b0);
        tz_bit = 1; cyc(1); expect_val("R7", 2, 1'b1); tz_bit = 0; cyc(1); expect_val("R7", 2, 1'b0);
        mclk_lost = 1; cyc(1); expect_val("R7", 2, 1'b1); mclk_lost = 0; cyc(1); expect_val("R7", 2, 1'b0);
        tx_pdn = 1; cyc(1); expect_val("R7", 2, 1'b1); tx_pdn = 0; cyc(1); expect_val("R7", 2, 1'b0);

        // R6 and R3: masked transition with a stuck-high level
        irq_mask = 1;
        stop_at(1'b1);
        cyc(73);
        expect_val("R3", 0, 1'b0);
        cyc(1);
        expect_val("R3", 0, 1'b1);
        expect_val("R6", 1, 1'b0);
        cyc(10);
        expect_val("R6", 1, 1'b0);
        irq_mask = 0;
        cyc(10);
        expect_val("R6", 1, 1'b0);

        done = 1;
        finish_run();
    end
endmodule